// File: doc/BRIEF.md
# Store-String Byte Sequencer

This block expands a single store-string-with-immediate-count request into a run of single-byte memory writes. A one-cycle start pulse carries four things: the first source register number, the number of the base register, the current value of that base register, and a 5-bit byte count. The block then walks the source registers through a combinational read port on a 32-entry, 32-bit register file. It emits one byte per valid/ready handshake on a byte-wide write port, at consecutive addresses.

The start address is taken from the base register unless the base register number is zero, in which case it is zero. A count of zero stands for the maximum run of 32 bytes. Bytes are taken from each register starting with the most significant one. After four bytes the source register number steps forward, wrapping from 31 to 0. The last register may be only partly consumed. `busy_o` stays high for the whole run, and `done_o` pulses once after the final byte has been accepted.

Top module: `strseq_top`

## Requirements
- R1: The first write address is 0 when `base_reg_i` is 0, and `base_val_i` otherwise.
- R2: A run makes exactly n accepted writes, where n is `count_i` when it is nonzero and 32 when `count_i` is 0.
- R3: Each accepted write is followed by one whose address is one higher (modulo 2^32).
- R4: Within a source register, write k of that register (k = 0..3) carries bits [31-8k:24-8k], so the most significant byte goes first.
- R5: The register read through `rf_raddr_o` starts at `src_reg_i` and advances by one after every fourth accepted byte, wrapping from 31 to 0. A run uses ceil(n/4) registers.
- R6: While `wr_valid_o` is high and `wr_ready_i` is low, the address, data and strobe hold, and no internal progress is made.
- R7: While `wr_valid_o` is high, `wr_strb_o` is one-hot with bit `wr_addr_o[1:0]` set. It is all zero while `wr_valid_o` is low.
- R8: A start pulse that arrives while `busy_o` is high has no effect on the run in progress.
- R9: `done_o` is high for exactly the one cycle after the edge that accepts the final byte. In that cycle `busy_o` and `wr_valid_o` are already low.
- R10: With `rst` high at a clock edge, the block returns to idle: `busy_o`, `wr_valid_o` and `done_o` are low afterwards.
- R11: `busy_o` and `wr_valid_o` rise in the cycle after an accepted start, and `wr_valid_o` equals `busy_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request pulse |
| src_reg_i | input | 5 | First source register number |
| base_reg_i | input | 5 | Base register number (0 selects address zero) |
| base_val_i | input | 32 | Contents of the base register |
| count_i | input | 5 | Byte count, 0 means 32 |
| rf_raddr_o | output | 5 | Register file read address |
| rf_rdata_i | input | 32 | Register file read data, same cycle |
| wr_valid_o | output | 1 | Byte write valid |
| wr_ready_i | input | 1 | Byte write ready |
| wr_addr_o | output | 32 | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| wr_strb_o | output | 4 | Byte lane strobe, one-hot on address bits [1:0] |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rf_rdata_i` is a pure function of `rf_raddr_o` for the length of a run, so nothing writes the register file while a run is in progress. They also assume that `rst` is a clean synchronous level and that `wr_ready_i` is never X while valid is high. The bench models the register file as a fixed function of the read address, so the read data follows the read address within the same cycle. It drives ready and start only at falling edges. Ready follows three fixed stall patterns, and no other agent touches the register file between or during runs.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

   // Encoded phase of the sequencer; kept as a type so the cursor reads clearly.
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } strseq_phase_e;

   // Number of bytes packed into one source register.
   function automatic int lanes_of(input int reg_w, input int byte_w);
      return reg_w / byte_w;
   endfunction

   // Index width that is never zero.
   function automatic int idx_w(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/strseq_launch.sv
module strseq_launch
   import strseq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int RIDX_W = 5,
   parameter int CNT_W  = 5
) (
   input  logic              start_i,
   input  logic              busy_i,
   input  logic [RIDX_W-1:0] base_reg_i,
   input  logic [ADDR_W-1:0] base_val_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              load_o,
   output logic [ADDR_W-1:0] first_addr_o,
   output logic [CNT_W:0]    total_o
);

   localparam logic [CNT_W:0] MAX_RUN = {1'b1, {CNT_W{1'b0}}};

   if (CNT_W < 1) begin : g_bad_cnt
      $error("strseq_launch: CNT_W must be at least 1");
   end

   // Only an idle sequencer takes a request; a pulse during a run is dropped.
   assign load_o = start_i & ~busy_i;

   // Register zero in the base field means an absolute address of zero.
   always_comb begin
      if (base_reg_i == '0) first_addr_o = '0;
      else                  first_addr_o = base_val_i;
   end

   // A zero immediate stands for the largest run the field can name.
   always_comb begin
      if (count_i == '0) total_o = MAX_RUN;
      else               total_o = {1'b0, count_i};
   end

endmodule

// File: rtl/strseq_lane.sv
module strseq_lane
   import strseq_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int BYTE_W    = 8,
   parameter int MEM_LANES = 4,
   parameter bit MSB_FIRST = 1'b1,
   localparam int LANES    = REG_W / BYTE_W,
   localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int SEL_W    = (MEM_LANES > 1) ? $clog2(MEM_LANES) : 1
) (
   input  logic              valid_i,
   input  logic [REG_W-1:0]  rdata_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [SEL_W-1:0]  addr_lo_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic [MEM_LANES-1:0] strb_o
);

   if (REG_W % BYTE_W != 0) begin : g_bad_ratio
      $error("strseq_lane: REG_W must be a multiple of BYTE_W");
   end
   if (MEM_LANES < 1) begin : g_bad_mem
      $error("strseq_lane: MEM_LANES must be at least 1");
   end

   // Byte pick: order chosen at elaboration.
   if (MSB_FIRST) begin : g_msb
      always_comb begin
         byte_o = rdata_i[REG_W-1 - int'(lane_i)*BYTE_W -: BYTE_W];
      end
   end else begin : g_lsb
      always_comb begin
         byte_o = rdata_i[int'(lane_i)*BYTE_W +: BYTE_W];
      end
   end

   // Lane strobe: one bit per memory byte lane, keyed by low address bits.
   if (MEM_LANES == 1) begin : g_strb_one
      assign strb_o = valid_i;
      logic unused_lo;
      assign unused_lo = ^addr_lo_i;
   end else begin : g_strb_many
      for (genvar k = 0; k < MEM_LANES; k++) begin : g_bit
         assign strb_o[k] = valid_i & (addr_lo_i == SEL_W'(k));
      end
   end

   always_comb begin
      if (valid_i) begin
         assert_strb_onehot_R7 : assert ($countones(strb_o) == 1)
            else $error("strobe not one-hot while valid");
      end else begin
         assert_strb_idle_R7 : assert (strb_o == '0)
            else $error("strobe active while not valid");
      end
   end

endmodule

// File: rtl/strseq_cursor.sv
module strseq_cursor
   import strseq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_REGS = 32,
   parameter int LANES    = 4,
   parameter int CNT_W    = 5,
   localparam int RIDX_W  = idx_w(NUM_REGS),
   localparam int LANE_W  = idx_w(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              start_i,
   input  logic [RIDX_W-1:0] src_reg_i,
   input  logic [ADDR_W-1:0] first_addr_i,
   input  logic [CNT_W:0]    total_i,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [RIDX_W-1:0] reg_o,
   output logic [LANE_W-1:0] lane_o
);

   localparam logic [CNT_W:0]    ONE_LEFT = {{CNT_W{1'b0}}, 1'b1};
   localparam logic [LANE_W-1:0] LAST_LN  = LANE_W'(LANES - 1);
   localparam logic [RIDX_W-1:0] LAST_RG  = RIDX_W'(NUM_REGS - 1);

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("strseq_cursor: NUM_REGS must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("strseq_cursor: LANES must be at least 1");
   end

   strseq_phase_e     phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W:0]    left_q;
   logic [RIDX_W-1:0] reg_q;
   logic [LANE_W-1:0] lane_q;
   logic              done_q;

   logic accept, final_beat, reg_step;

   assign accept     = (phase_q == PH_RUN) & ready_i;
   assign final_beat = accept & (left_q == ONE_LEFT);
   assign reg_step   = accept & (lane_q == LAST_LN);

   // Next register number, wrapping modulo NUM_REGS.
   logic [RIDX_W-1:0] reg_nxt;
   if ((1 << RIDX_W) == NUM_REGS) begin : g_wrap_pow2
      assign reg_nxt = reg_q + 1'b1;
   end else begin : g_wrap_cmp
      assign reg_nxt = (reg_q == LAST_RG) ? '0 : reg_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         reg_q   <= '0;
         lane_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= final_beat;
         if (load_i) begin
            phase_q <= PH_RUN;
            addr_q  <= first_addr_i;
            left_q  <= total_i;
            reg_q   <= src_reg_i;
            lane_q  <= '0;
         end else if (accept) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (final_beat) phase_q <= PH_IDLE;
            if (reg_step) begin
               lane_q <= '0;
               reg_q  <= reg_nxt;
            end else begin
               lane_q <= lane_q + 1'b1;
            end
         end
      end
   end

   assign busy_o = (phase_q == PH_RUN);
   assign done_o = done_q;
   assign addr_o = addr_q;
   assign reg_o  = reg_q;
   assign lane_o = lane_q;

   // Stalled beat keeps every piece of progress where it was.
   assert_stall_hold_R6 : assert property (@(posedge clk) disable iff (rst)
      (busy_o && !ready_i) |=> ($stable(addr_q) && $stable(left_q) &&
                                $stable(reg_q) && $stable(lane_q) && busy_o))
      else $error("state moved during stall");

   // Each accepted beat moves the address up by one.
   assert_addr_step_R3 : assert property (@(posedge clk) disable iff (rst)
      (busy_o && ready_i && !final_beat) |=> (addr_q == $past(addr_q) + 1'b1))
      else $error("address did not step by one");

   // Register number wraps to zero after the top register is used up.
   assert_reg_wrap_R5 : assert property (@(posedge clk) disable iff (rst)
      (reg_step && !final_beat && reg_q == LAST_RG) |=> (reg_q == '0))
      else $error("register number failed to wrap");

   // A request during a run leaves the remaining count alone.
   assert_ignore_start_R8 : assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i && !ready_i) |=> $stable(left_q))
      else $error("start during run disturbed count");

   // Completion pulse lasts one cycle and follows the run.
   assert_done_pulse_R9 : assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy_o && $past(busy_o)) ##0 1'b1)
      else $error("done without preceding run end");
   assert_done_once_R9 : assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o)
      else $error("done longer than one cycle");

   // Reset leaves the block idle.
   assert_reset_idle_R10 : assert property (@(posedge clk)
      rst |=> (!busy_o && !done_o))
      else $error("not idle after reset");

endmodule

// File: rtl/strseq_top.sv
module strseq_top
   import strseq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 32,
   parameter int BYTE_W    = 8,
   parameter int NUM_REGS  = 32,
   parameter int CNT_W     = 5,
   parameter int MEM_LANES = 4,
   parameter bit MSB_FIRST = 1'b1,
   localparam int RIDX_W   = idx_w(NUM_REGS),
   localparam int LANES    = lanes_of(REG_W, BYTE_W),
   localparam int LANE_W   = idx_w(LANES),
   localparam int SEL_W    = idx_w(MEM_LANES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start_i,
   input  logic [RIDX_W-1:0]    src_reg_i,
   input  logic [RIDX_W-1:0]    base_reg_i,
   input  logic [ADDR_W-1:0]    base_val_i,
   input  logic [CNT_W-1:0]     count_i,
   output logic [RIDX_W-1:0]    rf_raddr_o,
   input  logic [REG_W-1:0]     rf_rdata_i,
   output logic                 wr_valid_o,
   input  logic                 wr_ready_i,
   output logic [ADDR_W-1:0]    wr_addr_o,
   output logic [BYTE_W-1:0]    wr_data_o,
   output logic [MEM_LANES-1:0] wr_strb_o,
   output logic                 busy_o,
   output logic                 done_o
);

   if (ADDR_W < SEL_W) begin : g_bad_addr
      $error("strseq_top: ADDR_W too small for MEM_LANES");
   end

   logic              load;
   logic [ADDR_W-1:0] first_addr;
   logic [CNT_W:0]    total;
   logic              busy;
   logic [LANE_W-1:0] lane;

   strseq_launch #(
      .ADDR_W (ADDR_W),
      .RIDX_W (RIDX_W),
      .CNT_W  (CNT_W)
   ) u_launch (
      .start_i      (start_i),
      .busy_i       (busy),
      .base_reg_i   (base_reg_i),
      .base_val_i   (base_val_i),
      .count_i      (count_i),
      .load_o       (load),
      .first_addr_o (first_addr),
      .total_o      (total)
   );

   strseq_cursor #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .LANES    (LANES),
      .CNT_W    (CNT_W)
   ) u_cursor (
      .clk          (clk),
      .rst          (rst),
      .load_i       (load),
      .start_i      (start_i),
      .src_reg_i    (src_reg_i),
      .first_addr_i (first_addr),
      .total_i      (total),
      .ready_i      (wr_ready_i),
      .busy_o       (busy),
      .done_o       (done_o),
      .addr_o       (wr_addr_o),
      .reg_o        (rf_raddr_o),
      .lane_o       (lane)
   );

   strseq_lane #(
      .REG_W     (REG_W),
      .BYTE_W    (BYTE_W),
      .MEM_LANES (MEM_LANES),
      .MSB_FIRST (MSB_FIRST)
   ) u_lane (
      .valid_i   (busy),
      .rdata_i   (rf_rdata_i),
      .lane_i    (lane),
      .addr_lo_i (wr_addr_o[SEL_W-1:0]),
      .byte_o    (wr_data_o),
      .strb_o    (wr_strb_o)
   );

   assign busy_o     = busy;
   assign wr_valid_o = busy;

   // Outputs of a stalled beat stay put until taken.
   assert_hold_outputs_R6 : assert property (@(posedge clk) disable iff (rst)
      (wr_valid_o && !wr_ready_i) |=>
         (wr_valid_o && $stable(wr_addr_o) && $stable(wr_strb_o) && $stable(rf_raddr_o)))
      else $error("write beat changed before acceptance");

   // An accepted request opens a run on the next cycle.
   assert_run_opens_R11 : assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> (busy_o && wr_valid_o))
      else $error("run did not open after start");

endmodule

// File: tb/tb_strseq_top.sv
module tb_strseq_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        start_i;
   logic [4:0]  src_reg_i, base_reg_i, count_i;
   logic [31:0] base_val_i;
   logic [4:0]  rf_raddr_o;
   logic [31:0] rf_rdata_i;
   logic        wr_valid_o, wr_ready_i;
   logic [31:0] wr_addr_o;
   logic [7:0]  wr_data_o;
   logic [3:0]  wr_strb_o;
   logic        busy_o, done_o;

   int n_checks = 0;
   int n_errs   = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   strseq_top dut (
      .clk(clk), .rst(rst), .start_i(start_i), .src_reg_i(src_reg_i),
      .base_reg_i(base_reg_i), .base_val_i(base_val_i), .count_i(count_i),
      .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
      .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_strb_o(wr_strb_o), .busy_o(busy_o), .done_o(done_o)
   );

   // Register file model: distinct bytes in every register.
   function automatic logic [31:0] rf_val(input logic [4:0] k);
      logic [7:0] kb;
      kb = {3'b000, k};
      return {kb ^ 8'hC0, kb ^ 8'h5A, kb + 8'h80, ~kb};
   endfunction

   assign rf_rdata_i = rf_val(rf_raddr_o);

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic bit ready_pat(input int mode, input int cyc);
      case (mode)
         0:       return 1'b1;
         1:       return (cyc % 3) != 0;
         default: return (cyc % 2) == 0;
      endcase
   endfunction

   // One run; inject!=0 pulses a competing start in the middle.
   task automatic run(input logic [4:0] src, input logic [4:0] breg,
                      input logic [31:0] bval, input logic [4:0] cnt,
                      input int mode, input bit inject);
      int          n, b, cyc;
      bit          acc;
      logic [31:0] a0, ea, word;
      logic [4:0]  er;
      int          ln;
      n  = (cnt == 0) ? 32 : int'(cnt);
      a0 = (breg == 0) ? 32'h0 : bval;
      @(negedge clk);
      src_reg_i = src; base_reg_i = breg; base_val_i = bval; count_i = cnt;
      start_i = 1'b1; wr_ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && wr_valid_o, "R11 busy/valid after start", {30'b0, busy_o, wr_valid_o}, 32'h3);
      b = 0; acc = 1'b0; cyc = 0;
      forever begin
         if (cyc != 0) @(negedge clk);
         start_i = 1'b0;
         if (acc) b++;
         if (b == n) break;
         ea   = a0 + b;
         er   = src + 5'(b / 4);
         ln   = b % 4;
         word = rf_val(er);
         chk(wr_valid_o === 1'b1, "R2 valid during run", {31'b0, wr_valid_o}, 32'h1);
         chk(wr_addr_o == ea, (b == 0) ? "R1 first address" : "R3 address step", wr_addr_o, ea);
         chk(rf_raddr_o == er, "R5 register walk", {27'b0, rf_raddr_o}, {27'b0, er});
         chk(wr_data_o == word[31 - 8*ln -: 8], "R4 byte order", {24'b0, wr_data_o},
             {24'b0, word[31 - 8*ln -: 8]});
         chk(wr_strb_o == (4'b0001 << ea[1:0]), "R7 strobe", {28'b0, wr_strb_o},
             {28'b0, 4'b0001 << ea[1:0]});
         if (inject && b == 2) begin
            // R8: competing request mid-run
            start_i = 1'b1; src_reg_i = 5'd0; base_reg_i = 5'd0; count_i = 5'd3;
         end
         wr_ready_i = ready_pat(mode, cyc);
         acc = wr_ready_i;
         cyc++;
      end
      wr_ready_i = 1'b0;
      chk(done_o === 1'b1, "R9 done after final byte", {31'b0, done_o}, 32'h1);
      chk(!busy_o && !wr_valid_o, "R2 run stops after n bytes", {30'b0, busy_o, wr_valid_o}, 32'h0);
      chk(b == n, "R2 byte count", b, n);
      @(negedge clk);
      chk(done_o === 1'b0, "R9 done is one cycle", {31'b0, done_o}, 32'h0);
   endtask

   localparam int NV = 6;
   localparam logic [4:0]  V_SRC [NV] = '{5'd3, 5'd30, 5'd31, 5'd0, 5'd29, 5'd10};
   localparam logic [4:0]  V_BRG [NV] = '{5'd0, 5'd7, 5'd1, 5'd2, 5'd31, 5'd5};
   localparam logic [31:0] V_BVL [NV] = '{32'hDEAD_BEEF, 32'h1000_0FFE, 32'hFFFF_FFFF,
                                          32'h0000_0200, 32'h0000_0033, 32'h0000_ABC1};
   localparam logic [4:0]  V_CNT [NV] = '{5'd5, 5'd0, 5'd2, 5'd4, 5'd7, 5'd31};
   localparam int          V_MOD [NV] = '{0, 1, 0, 2, 1, 2};

   initial begin
      rst = 1'b1; start_i = 1'b0; wr_ready_i = 1'b0;
      src_reg_i = '0; base_reg_i = '0; base_val_i = '0; count_i = '0;
      repeat (3) @(negedge clk);
      // R10: state while and after reset
      chk(!busy_o && !wr_valid_o && !done_o, "R10 reset idle",
          {29'b0, busy_o, wr_valid_o, done_o}, 32'h0);
      chk(wr_strb_o == 4'b0, "R7 strobe idle", {28'b0, wr_strb_o}, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         run(V_SRC[i], V_BRG[i], V_BVL[i], V_CNT[i], V_MOD[i], 1'b0);
      end

      // R8: start during run is dropped
      run(5'd6, 5'd9, 32'h0000_4000, 5'd9, 1, 1'b1);

      // R10: reset in the middle of a run
      @(negedge clk);
      src_reg_i = 5'd1; base_reg_i = 5'd3; base_val_i = 32'h100; count_i = 5'd20;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; wr_ready_i = 1'b1;
      repeat (3) @(negedge clk);
      wr_ready_i = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!busy_o && !wr_valid_o && !done_o, "R10 reset mid-run",
          {29'b0, busy_o, wr_valid_o, done_o}, 32'h0);
      repeat (2) @(negedge clk);
      chk(!busy_o && !done_o, "R10 stays idle", {30'b0, busy_o, done_o}, 32'h0);

      // Block runs normally after the reset.
      run(5'd31, 5'd0, 32'h0, 5'd6, 0, 1'b0);

      summary();
   end

endmodule